// File: doc/BRIEF.md
# DMA Descriptor Pointer Sequencer

This block keeps the current source and destination descriptor pointers of one scatter-gather DMA channel. It fetches the 16-byte descriptors those pointers address, decodes them, and steps each pointer to the next descriptor. A pointer is 49 bits wide. The payload mover sits beside this block. It reads the decoded buffer address, size and flags. It pulses a command when it wants the next descriptor on one side: at channel start, when a source descriptor has been consumed, or when the destination descriptor's remaining size has run out.

Descriptors come over a simple read port. A one-cycle request carries a word address and a beat count. The memory then returns that many 32-bit words in order, one per valid cycle. Only one fetch is in flight at a time. Each descriptor's type bit picks how its pointer advances. A linear descriptor moves the pointer on by 16 bytes. A linked descriptor makes the block read a 64-bit next pointer stored directly behind the descriptor. In register-pointer mode the block touches no memory and takes both descriptors from programmed register inputs.

Top module: `dps_seq`

## Requirements
- R1: After a synchronous reset, busy_o, err_o, both error causes and mem_req_valid_o are 0, and both current pointers are 0.
- R2: start_i in memory mode copies the source start input to the source pointer and the destination start input to the destination pointer. It then fetches the destination descriptor: a request at the destination pointer with mem_req_len_o = 4. After that it fetches the source descriptor: a request at the source pointer with length 4.
- R3: The four fetched words of a descriptor are numbered 0 to 3 in response order and decoded as follows. The buffer address is word 1 bits 16:0 placed above all 32 bits of word 0. The size is word 2 bits 29:0. The command is word 3 bits 4:3. The interrupt flag is word 3 bit 2, the type is word 3 bit 1, and the coherent flag is word 3 bit 0. All other bits are ignored.
- R4: A descriptor pointer whose bits 3:0 are not all zero is never requested. At the point its fetch would be issued, err_o goes high. The cause output of the side being fetched (src_dscr_err_o or dst_dscr_err_o) pulses for exactly one cycle in that same cycle, and busy_o falls.
- R5: An advance command on a side whose current descriptor has type 0 adds 16 to that side's pointer and fetches the descriptor at the new pointer.
- R6: An advance command on a side whose current descriptor has type 1 first reads 2 words at pointer plus 16, with the low word first. The pointer becomes the lower 49 bits of the 64-bit value formed from those words. The descriptor at the new pointer is then fetched, after the alignment check of R4.
- R7: With mem_mode_i = 0, start_i and the advance commands issue no memory request and leave busy_o low. The affected side's descriptor is taken from its 128-bit register input, with word 0 in bits 31:0. start_i still copies both start inputs to the pointers, without any alignment check.
- R8: busy_o rises on the clock edge that accepts a memory-mode command. It stays high until the last word of the final fetch has been received, or until an alignment error. Every request lasts one cycle and is followed by no other request until all of its words have arrived.
- R9: A command arriving while busy_o is high is ignored. While err_o is high the advance commands are ignored. start_i clears err_o. Priority within one cycle is start, then destination advance, then source advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load pointers from start inputs and fetch both descriptors |
| adv_src_i | input | 1 | Advance the source pointer and fetch its next descriptor |
| adv_dst_i | input | 1 | Advance the destination pointer and fetch its next descriptor |
| mem_mode_i | input | 1 | 1: descriptors in memory, 0: descriptors from register inputs |
| src_start_i | input | 49 | Source start pointer |
| dst_start_i | input | 49 | Destination start pointer |
| src_reg_dscr_i | input | 128 | Source descriptor for register-pointer mode |
| dst_reg_dscr_i | input | 128 | Destination descriptor for register-pointer mode |
| mem_req_valid_o | output | 1 | One-cycle read request |
| mem_req_addr_o | output | 49 | Byte address of the first word requested |
| mem_req_len_o | output | 3 | Number of 32-bit words requested |
| mem_rsp_valid_i | input | 1 | Response word valid |
| mem_rsp_data_i | input | 32 | Response word |
| busy_o | output | 1 | Fetch sequence in progress |
| err_o | output | 1 | Sticky descriptor alignment error |
| src_dscr_err_o | output | 1 | One-cycle cause: source descriptor fetch failed |
| dst_dscr_err_o | output | 1 | One-cycle cause: destination descriptor fetch failed |
| src_ptr_o | output | 49 | Current source descriptor pointer |
| dst_ptr_o | output | 49 | Current destination descriptor pointer |
| src_buf_addr_o | output | 49 | Source descriptor buffer address |
| src_size_o | output | 30 | Source descriptor byte size |
| src_cmd_o | output | 2 | Source descriptor command |
| src_intr_o | output | 1 | Source descriptor interrupt flag |
| src_type_o | output | 1 | Source descriptor type (0 linear, 1 linked) |
| src_coh_o | output | 1 | Source descriptor coherent flag |
| dst_buf_addr_o | output | 49 | Destination descriptor buffer address |
| dst_size_o | output | 30 | Destination descriptor byte size |
| dst_cmd_o | output | 2 | Destination descriptor command field as stored |
| dst_intr_o | output | 1 | Destination descriptor interrupt flag |
| dst_type_o | output | 1 | Destination descriptor type |
| dst_coh_o | output | 1 | Destination descriptor coherent flag |

## Verification
Suppose the sequencer state goes wrong: the wrong side is selected, the word count is off, or the link assembly is bad. The very next request then carries the wrong address or length, and the bench's per-clock request comparison flags it in the cycle it is issued. A word written into the wrong slot or the wrong side shows up in the decoded outputs as soon as busy_o falls. A lost alignment check shows up as a request with a nonzero low nibble, or as a missing cause pulse on the edge where busy_o drops. Commands that should have been ignored show up as unexpected requests.

// File: rtl/dps_pkg.sv
package dps_pkg;

  localparam int SIDE_SRC = 0;
  localparam int SIDE_DST = 1;

  // control-word field positions in descriptor word 3
  localparam int CMD_LSB  = 3;
  localparam int CMD_W    = 2;
  localparam int INTR_BIT = 2;
  localparam int TYPE_BIT = 1;
  localparam int COH_BIT  = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_LINK,
    ST_RECV,
    ST_RECVL
  } seq_state_t;

endpackage

// File: rtl/dps_dscr_store.sv
module dps_dscr_store #(
  parameter int DW    = 32,
  parameter int WORDS = 4,
  localparam int CNT_W = $clog2(WORDS),
  localparam int TOT_W = WORDS * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic [DW-1:0]    data_i,
  input  logic             ld_i,
  input  logic [TOT_W-1:0] ld_words_i,
  output logic [TOT_W-1:0] words_o
);

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [DW-1:0] word_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= '0;
      end else if (ld_i) begin
        word_q <= ld_words_i[g*DW +: DW];
      end else if (we_i && (idx_i == CNT_W'(g))) begin
        word_q <= data_i;
      end
    end

    assign words_o[g*DW +: DW] = word_q;
  end

endmodule

// File: rtl/dps_dscr_decode.sv
module dps_dscr_decode
  import dps_pkg::*;
#(
  parameter int AW     = 49,
  parameter int DW     = 32,
  parameter int WORDS  = 4,
  parameter int SIZE_W = 30,
  localparam int TOT_W = WORDS * DW,
  localparam int HI_W  = AW - DW
) (
  input  logic [TOT_W-1:0]  words_i,
  output logic [AW-1:0]     buf_addr_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              intr_o,
  output logic              type_o,
  output logic              coh_o
);

  logic [DW-1:0] w0, w1, w2, w3;

  assign w0 = words_i[0*DW +: DW];
  assign w1 = words_i[1*DW +: DW];
  assign w2 = words_i[2*DW +: DW];
  assign w3 = words_i[3*DW +: DW];

  assign buf_addr_o = {w1[HI_W-1:0], w0};
  assign size_o     = w2[SIZE_W-1:0];
  assign cmd_o      = w3[CMD_LSB +: CMD_W];
  assign intr_o     = w3[INTR_BIT];
  assign type_o     = w3[TYPE_BIT];
  assign coh_o      = w3[COH_BIT];

  logic unused_bits;
  assign unused_bits = ^{w1[DW-1:HI_W], w2[DW-1:SIZE_W], w3[DW-1:CMD_LSB+CMD_W]};

endmodule

// File: rtl/dps_ctrl.sv
module dps_ctrl
  import dps_pkg::*;
#(
  parameter int AW         = 49,
  parameter int DW         = 32,
  parameter int WORDS      = 4,
  parameter int LINK_WORDS = 2,
  parameter int DSCR_BYTES = 16,
  localparam int CNT_W  = $clog2(WORDS),
  localparam int LEN_W  = $clog2(WORDS + 1),
  localparam int AL_W   = $clog2(DSCR_BYTES),
  localparam int LINK_W = LINK_WORDS * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             adv_src_i,
  input  logic             adv_dst_i,
  input  logic             mem_mode_i,
  input  logic [AW-1:0]    src_start_i,
  input  logic [AW-1:0]    dst_start_i,
  input  logic             src_type_i,
  input  logic             dst_type_i,
  input  logic             mem_rsp_valid_i,
  input  logic [DW-1:0]    mem_rsp_data_i,
  output logic             mem_req_valid_o,
  output logic [AW-1:0]    mem_req_addr_o,
  output logic [LEN_W-1:0] mem_req_len_o,
  output logic [1:0]       dscr_we_o,
  output logic [CNT_W-1:0] dscr_idx_o,
  output logic [DW-1:0]    dscr_data_o,
  output logic [1:0]       reg_ld_o,
  output logic [AW-1:0]    src_ptr_o,
  output logic [AW-1:0]    dst_ptr_o,
  output logic             busy_o,
  output logic             err_o,
  output logic             src_err_o,
  output logic             dst_err_o
);

  seq_state_t st_q;
  logic              side_q;
  logic              chain_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LINK_W-DW-1:0] link_q;
  logic [AW-1:0]     ptr_q [2];
  logic              busy_q, err_q, req_v_q;
  logic [1:0]        errp_q;
  logic [AW-1:0]     req_addr_q;
  logic [LEN_W-1:0]  req_len_q;

  // command decode, priority start > destination > source
  logic idle, cmd_start, cmd_dst, cmd_src, cmd_side, cmd_type;
  assign idle      = (st_q == ST_IDLE);
  assign cmd_start = start_i;
  assign cmd_dst   = !start_i && !err_q && adv_dst_i;
  assign cmd_src   = !start_i && !err_q && !adv_dst_i && adv_src_i;
  assign cmd_side  = cmd_dst;
  assign cmd_type  = cmd_dst ? dst_type_i : src_type_i;

  logic [AW-1:0] cur_ptr;
  logic          misal;
  assign cur_ptr = ptr_q[side_q];
  assign misal   = |cur_ptr[AL_W-1:0];

  logic [LINK_W-1:0] link_nx;
  assign link_nx = {mem_rsp_data_i, link_q};

  logic unused_link;
  assign unused_link = ^link_nx[LINK_W-1:AW];

  logic rsp_take;
  assign rsp_take = (st_q == ST_RECV) && mem_rsp_valid_i;

  assign dscr_we_o[SIDE_SRC] = rsp_take && (side_q == 1'(SIDE_SRC));
  assign dscr_we_o[SIDE_DST] = rsp_take && (side_q == 1'(SIDE_DST));
  assign dscr_idx_o          = cnt_q;
  assign dscr_data_o         = mem_rsp_data_i;

  assign reg_ld_o[SIDE_SRC] = idle && !mem_mode_i && (cmd_start || cmd_src);
  assign reg_ld_o[SIDE_DST] = idle && !mem_mode_i && (cmd_start || cmd_dst);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      side_q     <= 1'b0;
      chain_q    <= 1'b0;
      cnt_q      <= '0;
      link_q     <= '0;
      ptr_q[0]   <= '0;
      ptr_q[1]   <= '0;
      busy_q     <= 1'b0;
      err_q      <= 1'b0;
      errp_q     <= '0;
      req_v_q    <= 1'b0;
      req_addr_q <= '0;
      req_len_q  <= '0;
    end else begin
      req_v_q <= 1'b0;
      errp_q  <= '0;
      unique case (st_q)
        ST_IDLE: begin
          if (cmd_start) begin
            ptr_q[SIDE_SRC] <= src_start_i;
            ptr_q[SIDE_DST] <= dst_start_i;
            err_q           <= 1'b0;
            if (mem_mode_i) begin
              side_q  <= 1'(SIDE_DST);
              chain_q <= 1'b1;
              busy_q  <= 1'b1;
              st_q    <= ST_CHECK;
            end
          end else if ((cmd_dst || cmd_src) && mem_mode_i) begin
            side_q  <= cmd_side;
            chain_q <= 1'b0;
            busy_q  <= 1'b1;
            if (cmd_type) begin
              st_q <= ST_LINK;
            end else begin
              ptr_q[cmd_side] <= ptr_q[cmd_side] + AW'(DSCR_BYTES);
              st_q            <= ST_CHECK;
            end
          end
        end
        ST_CHECK, ST_LINK: begin
          if (misal) begin
            err_q          <= 1'b1;
            errp_q[side_q] <= 1'b1;
            busy_q         <= 1'b0;
            st_q           <= ST_IDLE;
          end else begin
            req_v_q <= 1'b1;
            cnt_q   <= '0;
            if (st_q == ST_CHECK) begin
              req_addr_q <= cur_ptr;
              req_len_q  <= LEN_W'(WORDS);
              st_q       <= ST_RECV;
            end else begin
              req_addr_q <= cur_ptr + AW'(DSCR_BYTES);
              req_len_q  <= LEN_W'(LINK_WORDS);
              st_q       <= ST_RECVL;
            end
          end
        end
        ST_RECV: begin
          if (mem_rsp_valid_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(WORDS - 1)) begin
              if (chain_q) begin
                chain_q <= 1'b0;
                side_q  <= 1'(SIDE_SRC);
                st_q    <= ST_CHECK;
              end else begin
                busy_q <= 1'b0;
                st_q   <= ST_IDLE;
              end
            end
          end
        end
        ST_RECVL: begin
          if (mem_rsp_valid_i) begin
            cnt_q  <= cnt_q + 1'b1;
            link_q <= link_nx[LINK_W-1:DW];
            if (cnt_q == CNT_W'(LINK_WORDS - 1)) begin
              ptr_q[side_q] <= link_nx[AW-1:0];
              st_q          <= ST_CHECK;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid_o = req_v_q;
  assign mem_req_addr_o  = req_addr_q;
  assign mem_req_len_o   = req_len_q;
  assign src_ptr_o       = ptr_q[SIDE_SRC];
  assign dst_ptr_o       = ptr_q[SIDE_DST];
  assign busy_o          = busy_q;
  assign err_o           = err_q;
  assign src_err_o       = errp_q[SIDE_SRC];
  assign dst_err_o       = errp_q[SIDE_DST];

  // R8
  single_req_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid_o |=> !mem_req_valid_o);

  // R8
  req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid_o |-> busy_o);

  // R4
  req_align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid_o |-> (mem_req_addr_o[AL_W-1:0] == '0));

  // R4
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> ($countones({src_err_o, dst_err_o}) == 1) && !busy_o);

  // R4
  cause_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({src_err_o, dst_err_o}));

  // R9
  err_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    (err_o && $stable(err_o)) |-> !mem_req_valid_o);

endmodule

// File: rtl/dps_seq.sv
module dps_seq
  import dps_pkg::*;
#(
  parameter int AW         = 49,
  parameter int DW         = 32,
  parameter int WORDS      = 4,
  parameter int LINK_WORDS = 2,
  parameter int DSCR_BYTES = 16,
  parameter int SIZE_W     = 30,
  localparam int LEN_W  = $clog2(WORDS + 1),
  localparam int CNT_W  = $clog2(WORDS),
  localparam int TOT_W  = WORDS * DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              adv_src_i,
  input  logic              adv_dst_i,
  input  logic              mem_mode_i,
  input  logic [AW-1:0]     src_start_i,
  input  logic [AW-1:0]     dst_start_i,
  input  logic [TOT_W-1:0]  src_reg_dscr_i,
  input  logic [TOT_W-1:0]  dst_reg_dscr_i,
  output logic              mem_req_valid_o,
  output logic [AW-1:0]     mem_req_addr_o,
  output logic [LEN_W-1:0]  mem_req_len_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DW-1:0]     mem_rsp_data_i,
  output logic              busy_o,
  output logic              err_o,
  output logic              src_dscr_err_o,
  output logic              dst_dscr_err_o,
  output logic [AW-1:0]     src_ptr_o,
  output logic [AW-1:0]     dst_ptr_o,
  output logic [AW-1:0]     src_buf_addr_o,
  output logic [SIZE_W-1:0] src_size_o,
  output logic [CMD_W-1:0]  src_cmd_o,
  output logic              src_intr_o,
  output logic              src_type_o,
  output logic              src_coh_o,
  output logic [AW-1:0]     dst_buf_addr_o,
  output logic [SIZE_W-1:0] dst_size_o,
  output logic [CMD_W-1:0]  dst_cmd_o,
  output logic              dst_intr_o,
  output logic              dst_type_o,
  output logic              dst_coh_o
);

  logic [1:0]        dscr_we, reg_ld;
  logic [CNT_W-1:0]  dscr_idx;
  logic [DW-1:0]     dscr_data;

  logic [AW-1:0]     buf_a  [2];
  logic [SIZE_W-1:0] size_a [2];
  logic [CMD_W-1:0]  cmd_a  [2];
  logic [1:0]        intr_a, type_a, coh_a;

  dps_ctrl #(
    .AW(AW), .DW(DW), .WORDS(WORDS),
    .LINK_WORDS(LINK_WORDS), .DSCR_BYTES(DSCR_BYTES)
  ) u_ctrl (
    .clk             (clk),
    .rst             (rst),
    .start_i         (start_i),
    .adv_src_i       (adv_src_i),
    .adv_dst_i       (adv_dst_i),
    .mem_mode_i      (mem_mode_i),
    .src_start_i     (src_start_i),
    .dst_start_i     (dst_start_i),
    .src_type_i      (type_a[SIDE_SRC]),
    .dst_type_i      (type_a[SIDE_DST]),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_data_i  (mem_rsp_data_i),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_req_len_o   (mem_req_len_o),
    .dscr_we_o       (dscr_we),
    .dscr_idx_o      (dscr_idx),
    .dscr_data_o     (dscr_data),
    .reg_ld_o        (reg_ld),
    .src_ptr_o       (src_ptr_o),
    .dst_ptr_o       (dst_ptr_o),
    .busy_o          (busy_o),
    .err_o           (err_o),
    .src_err_o       (src_dscr_err_o),
    .dst_err_o       (dst_dscr_err_o)
  );

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic [TOT_W-1:0] words;
    logic [TOT_W-1:0] reg_words;
    logic             t_intr, t_type, t_coh;

    assign reg_words = (s == SIDE_SRC) ? src_reg_dscr_i : dst_reg_dscr_i;

    dps_dscr_store #(.DW(DW), .WORDS(WORDS)) u_store (
      .clk        (clk),
      .rst        (rst),
      .we_i       (dscr_we[s]),
      .idx_i      (dscr_idx),
      .data_i     (dscr_data),
      .ld_i       (reg_ld[s]),
      .ld_words_i (reg_words),
      .words_o    (words)
    );

    dps_dscr_decode #(.AW(AW), .DW(DW), .WORDS(WORDS), .SIZE_W(SIZE_W)) u_dec (
      .words_i    (words),
      .buf_addr_o (buf_a[s]),
      .size_o     (size_a[s]),
      .cmd_o      (cmd_a[s]),
      .intr_o     (t_intr),
      .type_o     (t_type),
      .coh_o      (t_coh)
    );

    assign intr_a[s] = t_intr;
    assign type_a[s] = t_type;
    assign coh_a[s]  = t_coh;
  end

  assign src_buf_addr_o = buf_a[SIDE_SRC];
  assign src_size_o     = size_a[SIDE_SRC];
  assign src_cmd_o      = cmd_a[SIDE_SRC];
  assign src_intr_o     = intr_a[SIDE_SRC];
  assign src_type_o     = type_a[SIDE_SRC];
  assign src_coh_o      = coh_a[SIDE_SRC];
  assign dst_buf_addr_o = buf_a[SIDE_DST];
  assign dst_size_o     = size_a[SIDE_DST];
  assign dst_cmd_o      = cmd_a[SIDE_DST];
  assign dst_intr_o     = intr_a[SIDE_DST];
  assign dst_type_o     = type_a[SIDE_DST];
  assign dst_coh_o      = coh_a[SIDE_DST];

endmodule

// File: tb/sim_dps_seq.sv
module sim_dps_seq;
  localparam int CLK_PERIOD = 10;
  localparam longint unsigned MASK49 = 64'h0001_FFFF_FFFF_FFFF;

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 0, adv_src_i = 0, adv_dst_i = 0, mem_mode_i = 1;
  logic [48:0] src_start_i = '0, dst_start_i = '0;
  logic [127:0] src_reg_dscr_i = '0, dst_reg_dscr_i = '0;
  logic mem_req_valid_o;
  logic [48:0] mem_req_addr_o;
  logic [2:0] mem_req_len_o;
  logic mem_rsp_valid_i = 0;
  logic [31:0] mem_rsp_data_i = '0;
  logic busy_o, err_o, src_dscr_err_o, dst_dscr_err_o;
  logic [48:0] src_ptr_o, dst_ptr_o, src_buf_addr_o, dst_buf_addr_o;
  logic [29:0] src_size_o, dst_size_o;
  logic [1:0] src_cmd_o, dst_cmd_o;
  logic src_intr_o, src_type_o, src_coh_o, dst_intr_o, dst_type_o, dst_coh_o;

  dps_seq u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0;

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model
  bit [31:0] ovr [longint unsigned];
  function automatic bit [31:0] memrd(longint unsigned a);
    bit [31:0] v;
    if (ovr.exists(a)) return ovr[a];
    v = (32'(a) * 32'h0001_9E37) ^ 32'h5A3C_0F00;
    v[1] = 1'b0;
    return v;
  endfunction

  bit [31:0] pend [$];
  longint unsigned exp_addr [$];
  int exp_len [$];
  string exp_tag [$];

  task automatic expect_req(input string tag, input longint unsigned a, input int n);
    exp_addr.push_back(a & MASK49);
    exp_len.push_back(n);
    exp_tag.push_back(tag);
  endtask

  // per-clock request comparison and response generation
  always @(negedge clk) begin
    if (!rst && mem_req_valid_o) begin
      if (exp_addr.size() == 0) begin
        chk("R9 unexpected request", 64'(mem_req_addr_o), 64'hFFFF_FFFF_FFFF_FFFF);
      end else begin
        string t;
        longint unsigned ea;
        int el;
        t = exp_tag.pop_front();
        ea = exp_addr.pop_front();
        el = exp_len.pop_front();
        chk({t, " req addr"}, 64'(mem_req_addr_o), ea);
        chk({t, " req len"}, 64'(mem_req_len_o), 64'(el));
      end
      for (int i = 0; i < int'(mem_req_len_o); i++)
        pend.push_back(memrd(64'(mem_req_addr_o) + 64'(4 * i)));
    end
    if (pend.size() > 0) begin
      mem_rsp_valid_i = 1'b1;
      mem_rsp_data_i  = pend.pop_front();
    end else begin
      mem_rsp_valid_i = 1'b0;
      mem_rsp_data_i  = '0;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  task automatic do_cmd(input int kind, input bit exp_busy, input string tag);
    @(negedge clk);
    start_i = (kind == 0); adv_src_i = (kind == 1); adv_dst_i = (kind == 2);
    @(negedge clk);
    start_i = 0; adv_src_i = 0; adv_dst_i = 0;
    chk({tag, " busy after command"}, 64'(busy_o), 64'(exp_busy));
    while (busy_o) @(negedge clk);
  endtask

  task automatic chk_dscr(input string tag, input bit dst,
                          input bit [31:0] w0, w1, w2, w3);
    longint unsigned ba;
    ba = {15'd0, w1[16:0], w0};
    if (dst) begin
      chk({tag, " dst addr"}, 64'(dst_buf_addr_o), ba);
      chk({tag, " dst size"}, 64'(dst_size_o), 64'(w2[29:0]));
      chk({tag, " dst flags"}, 64'({dst_cmd_o, dst_intr_o, dst_type_o, dst_coh_o}), 64'(w3[4:0]));
    end else begin
      chk({tag, " src addr"}, 64'(src_buf_addr_o), ba);
      chk({tag, " src size"}, 64'(src_size_o), 64'(w2[29:0]));
      chk({tag, " src flags"}, 64'({src_cmd_o, src_intr_o, src_type_o, src_coh_o}), 64'(w3[4:0]));
    end
  endtask

  task automatic chk_mem(input string tag, input bit dst, input longint unsigned p);
    chk_dscr(tag, dst, memrd(p), memrd(p + 4), memrd(p + 8), memrd(p + 12));
  endtask

  longint unsigned S, D, L;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(busy_o), 0);
    chk("R1 err", 64'(err_o), 0);
    chk("R1 causes", 64'({src_dscr_err_o, dst_dscr_err_o}), 0);
    chk("R1 req", 64'(mem_req_valid_o), 0);
    chk("R1 ptrs", 64'(src_ptr_o) | 64'(dst_ptr_o), 0);

    // R2/R3 start in memory mode
    S = 64'h1_2345_6780; D = 64'h0_00AB_CD00;
    ovr[S + 4]  = 32'hFFFF_ABCD;
    ovr[S + 8]  = 32'hC000_1234;
    ovr[S + 12] = 32'h0000_001D;
    ovr[D + 12] = 32'h0000_0006;
    src_start_i = 49'(S); dst_start_i = 49'(D); mem_mode_i = 1;
    expect_req("R2 dst first", D, 4);
    expect_req("R2 src second", S, 4);
    do_cmd(0, 1, "R8 start");
    chk("R2 src ptr", 64'(src_ptr_o), S);
    chk("R2 dst ptr", 64'(dst_ptr_o), D);
    chk_mem("R3 start", 0, S);
    chk_mem("R3 start", 1, D);
    chk("R2 queue drained", 64'(exp_addr.size()), 0);

    // R5 linear source advance
    expect_req("R5 linear src", S + 16, 4);
    do_cmd(1, 1, "R8 adv src");
    chk("R5 src ptr", 64'(src_ptr_o), S + 16);
    chk_mem("R5 fetched", 0, S + 16);

    // R6 linked destination advance, 49-bit truncation
    ovr[D + 16] = 32'h0000_4440;
    ovr[D + 20] = 32'hFFFF_0001;
    L = 64'h1_0001_0000_4440;
    expect_req("R6 link read", D + 16, 2);
    expect_req("R6 follow link", L, 4);
    do_cmd(2, 1, "R8 adv dst");
    chk("R6 dst ptr", 64'(dst_ptr_o), L);
    chk_mem("R6 fetched", 1, L);
    chk("R6 src ptr untouched", 64'(src_ptr_o), S + 16);

    // R9 advance during busy is ignored
    expect_req("R9 only dst", L + 16, 4);
    @(negedge clk); adv_dst_i = 1;
    @(negedge clk); adv_dst_i = 0; adv_src_i = 1;
    @(negedge clk); adv_src_i = 0;
    while (busy_o) @(negedge clk);
    chk("R9 dst ptr", 64'(dst_ptr_o), L + 16);
    chk("R9 src ptr unchanged", 64'(src_ptr_o), S + 16);

    // R4/R6 link to a misaligned pointer on source side
    ovr[S + 32 + 12] = 32'h0000_0002;
    expect_req("R5 src to linked", S + 32, 4);
    do_cmd(1, 1, "R8 adv src");
    chk("R3 src type linked", 64'(src_type_o), 1);
    ovr[S + 48] = 32'h0000_0108;
    ovr[S + 52] = 32'h0000_0000;
    expect_req("R6 link read", S + 48, 2);
    do_cmd(1, 1, "R8 adv src");
    chk("R4 err", 64'(err_o), 1);
    chk("R4 src cause", 64'(src_dscr_err_o), 1);
    chk("R4 dst cause", 64'(dst_dscr_err_o), 0);
    chk("R6 src ptr from link", 64'(src_ptr_o), 64'h108);
    @(negedge clk);
    chk("R4 cause one cycle", 64'(src_dscr_err_o), 0);

    // R9 advance while err is ignored
    do_cmd(2, 0, "R9 adv in err");
    chk("R9 dst ptr held", 64'(dst_ptr_o), L + 16);
    chk("R9 err held", 64'(err_o), 1);

    // R4 source start misaligned, destination fetched first
    src_start_i = 49'h0_0000_2004; dst_start_i = 49'(D);
    expect_req("R2 dst before src err", D, 4);
    do_cmd(0, 1, "R8 start");
    chk("R4 src cause start", 64'(src_dscr_err_o), 1);
    chk("R4 err start", 64'(err_o), 1);

    // R4 destination start misaligned: no request at all
    dst_start_i = 49'h0_0000_3008;
    do_cmd(0, 1, "R8 start");
    chk("R4 dst cause", 64'(dst_dscr_err_o), 1);
    chk("R4 no src cause", 64'(src_dscr_err_o), 0);

    // R9 start clears err
    src_start_i = 49'(S); dst_start_i = 49'(D);
    expect_req("R9 restart dst", D, 4);
    expect_req("R9 restart src", S, 4);
    do_cmd(0, 1, "R8 start");
    chk("R9 err cleared", 64'(err_o), 0);

    // R7 register-pointer mode
    mem_mode_i = 0;
    src_reg_dscr_i = {32'h0000_001A, 32'h4000_0100, 32'h0001_FFFF, 32'hCAFE_0000};
    dst_reg_dscr_i = {32'h0000_0005, 32'h0000_0040, 32'h0000_0000, 32'h0000_1000};
    src_start_i = 49'h3; dst_start_i = 49'h7;
    do_cmd(0, 0, "R7 start");
    chk("R7 src ptr", 64'(src_ptr_o), 64'h3);
    chk("R7 dst ptr", 64'(dst_ptr_o), 64'h7);
    chk("R7 err", 64'(err_o), 0);
    chk_dscr("R7 reg", 0, 32'hCAFE_0000, 32'h0001_FFFF, 32'h4000_0100, 32'h0000_001A);
    chk_dscr("R7 reg", 1, 32'h0000_1000, 32'h0000_0000, 32'h0000_0040, 32'h0000_0005);
    src_reg_dscr_i[95:64] = 32'h0000_0077;
    do_cmd(1, 0, "R7 adv src");
    chk("R7 reload size", 64'(src_size_o), 64'h77);
    chk("R7 ptr kept", 64'(src_ptr_o), 64'h3);
    chk("R7 dst kept", 64'(dst_size_o), 64'h40);

    repeat (4) @(negedge clk);
    chk("R8 no stray request", 64'(exp_addr.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule